// File: doc/BRIEF.md
# Entropy Source CSR Block

This block sits beside a processor's CSR file and serves two machine-level registers: a read-only entropy word and a noise-test control register. A CSR access port presents an address, an operation (read, write, set, clear), write data, the current privilege level and a flag that says the source register of the instruction is the zero register. One cycle later the block answers with read data, a hit flag and an illegal-instruction flag.

The entropy word carries a 2-bit status in bits 31:30 and a 16-bit seed in bits 15:0. A fresh 16-bit sample arrives on an abstract sample input with a valid strobe and is held until a legal read consumes it. When the noise-test bit is set, every entropy read reports the self-test status instead. The register width is a parameter; with 64-bit registers the upper half of every read is zero. A second parameter removes the noise-test register, which then reads as zero.

Top module: `entropy_csr_top`

## Requirements
- R1: Any access to either register with privilege other than machine (2'b11) returns illegal=1 and rdata=0, and changes no state (no sample consumed, noise-test bit unchanged).
- R2: An access to the entropy register with op WRITE (2'd1), or with op SET (2'd2) or CLEAR (2'd3) while the source-zero flag is 0, returns illegal=1, rdata=0 and consumes no sample.
- R3: SET or CLEAR with the source-zero flag at 1 on the entropy register behaves as a legal read (illegal=0), the same as op READ (2'd0).
- R4: The entropy word holds the status in bits 31:30 (BIST=00, WAIT=01, ES16=10, DEAD=11) and the seed in bits 15:0; bits 29:16 are zero, and the seed reads zero whenever the status is not ES16.
- R5: A legal entropy read with the noise-test bit clear returns ES16 and the held seed if a sample arrived since the last consuming read, and WAIT otherwise; an ES16 read consumes the sample. A sample strobed in the same cycle as a read is held for the next read.
- R6: While the noise-test bit is 1, a legal entropy read returns status BIST with seed 0 and does not consume the held sample.
- R7: The noise-test register's only bit is bit 31: WRITE loads wdata[31], SET ORs it in and CLEAR removes it (SET/CLEAR only when the source-zero flag is 0); reads return that bit in position 31 and zero elsewhere.
- R8: With 64-bit registers, bits 63:32 of every response are zero.
- R9: When the noise-test register is configured as absent, it reads as all zeros, machine-mode writes to it are legal and ignored, and entropy reads are never forced to BIST.
- R10: A response (rsp_valid=1) appears exactly one cycle after each request; an address that matches neither register gives hit=0, illegal=0, rdata=0, and with no request all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| csr_req_i | input | 1 | Access request strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_op_i | input | 2 | 0 READ, 1 WRITE, 2 SET, 3 CLEAR |
| csr_wdata_i | input | XLEN | Write / mask data |
| csr_priv_i | input | 2 | Privilege level, 3 is machine |
| csr_src_zero_i | input | 1 | Source register is the zero register |
| smp_valid_i | input | 1 | New entropy sample strobe |
| smp_data_i | input | 16 | Entropy sample |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_hit_o | output | 1 | Address matched one of the two registers |
| rsp_illegal_o | output | 1 | Illegal-instruction indication |
| rsp_rdata_o | output | XLEN | Read data |

## Verification
Assertions watch on every cycle the trap rules for lower privilege and entropy writes, the legal pure read through SET/CLEAR with a zero source, seed masking outside ES16, the forced BIST status, the zeroed upper half, the consume-on-read of the sample holder and the stability of the noise-test bit without a write. Only the bench's scenarios and its cycle-level reference model can show that the right seed value comes back, that a sample strobed during a read survives to the next read, that trapped accesses leave the held sample and the noise bit untouched, and that the absent noise register ignores writes.

// File: rtl/entropy_csr_pkg.sv
package entropy_csr_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef enum logic [1:0] {
    ST_BIST = 2'b00,
    ST_WAIT = 2'b01,
    ST_ES16 = 2'b10,
    ST_DEAD = 2'b11
  } ent_status_e;

  localparam logic [1:0] PRIV_MACHINE = 2'b11;
  localparam int SEED_W = 16;

  // Builds the 32-bit entropy word; the seed is masked outside ES16.
  function automatic logic [31:0] pack_entropy(input ent_status_e st,
                                               input logic [SEED_W-1:0] seed);
    logic [31:0] w;
    w        = '0;
    w[31:30] = st;
    if (st == ST_ES16) w[SEED_W-1:0] = seed;
    return w;
  endfunction

  // Next value of the noise-test bit for a given write form.
  function automatic logic noise_next(input csr_op_e op, input logic cur,
                                      input logic bit_in);
    case (op)
      OP_WRITE: return bit_in;
      OP_SET:   return cur | bit_in;
      OP_CLEAR: return cur & ~bit_in;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/entropy_access_chk.sv
module entropy_access_chk
  import entropy_csr_pkg::*;
#(
  parameter logic [11:0] ENT_ADDR   = 12'h015,
  parameter logic [11:0] NOISE_ADDR = 12'h7A9
) (
  input  logic        req_i,
  input  logic [11:0] addr_i,
  input  csr_op_e     op_i,
  input  logic [1:0]  priv_i,
  input  logic        src_zero_i,
  output logic        sel_ent_o,
  output logic        sel_noise_o,
  output logic        illegal_o,
  output logic        ent_read_ok_o,
  output logic        noise_read_ok_o,
  output logic        noise_wr_en_o
);
  logic wants_write;
  logic priv_ok;

  always_comb begin
    sel_ent_o   = req_i && (addr_i == ENT_ADDR);
    sel_noise_o = req_i && (addr_i == NOISE_ADDR);
    priv_ok     = (priv_i == PRIV_MACHINE);
    // WRITE always writes; SET/CLEAR write only with a non-zero source.
    wants_write = (op_i == OP_WRITE) ||
                  (((op_i == OP_SET) || (op_i == OP_CLEAR)) && !src_zero_i);
    illegal_o   = ((sel_ent_o || sel_noise_o) && !priv_ok) ||
                  (sel_ent_o && wants_write);
    ent_read_ok_o   = sel_ent_o && !illegal_o;
    noise_read_ok_o = sel_noise_o && !illegal_o;
    noise_wr_en_o   = noise_read_ok_o && wants_write;
  end
endmodule

// File: rtl/entropy_sample_buf.sv
module entropy_sample_buf
  import entropy_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [SEED_W-1:0] smp_data_i,
  input  logic              consume_i,
  output logic              fresh_o,
  output logic [SEED_W-1:0] seed_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      fresh_o <= 1'b0;
      seed_o  <= '0;
    end else if (smp_valid_i) begin
      fresh_o <= 1'b1;
      seed_o  <= smp_data_i;
    end else if (consume_i) begin
      fresh_o <= 1'b0;
    end
  end

  AST_CONSUME_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i && !smp_valid_i |=> !fresh_o); // R5
  AST_SAMPLE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> fresh_o && seed_o == $past(smp_data_i)); // R5
endmodule

// File: rtl/noise_test_reg.sv
module noise_test_reg
  import entropy_csr_pkg::*;
#(
  parameter bit IMPL = 1'b1
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wr_en_i,
  input  csr_op_e op_i,
  input  logic    bit_i,
  output logic    noise_o
);
  generate
    if (IMPL) begin : g_impl
      logic noise_q;
      always_ff @(posedge clk_i) begin
        if (!rst_ni)      noise_q <= 1'b0;
        else if (wr_en_i) noise_q <= noise_next(op_i, noise_q, bit_i);
      end
      assign noise_o = noise_q;
    end else begin : g_absent
      assign noise_o = 1'b0;
      AST_NOISE_ABSENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> !noise_o); // R9
    end
  endgenerate

  AST_NOISE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(noise_o)); // R7
endmodule

// File: rtl/entropy_csr_top.sv
module entropy_csr_top
  import entropy_csr_pkg::*;
#(
  parameter int          XLEN       = 64,
  parameter bit          NOISE_IMPL = 1'b1,
  parameter logic [11:0] ENT_ADDR   = 12'h015,
  parameter logic [11:0] NOISE_ADDR = 12'h7A9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_req_i,
  input  logic [11:0]       csr_addr_i,
  input  logic [1:0]        csr_op_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  input  logic [1:0]        csr_priv_i,
  input  logic              csr_src_zero_i,
  input  logic              smp_valid_i,
  input  logic [SEED_W-1:0] smp_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_illegal_o,
  output logic [XLEN-1:0]   rsp_rdata_o
);
  localparam int WORD_W = 32;

  csr_op_e           op;
  logic              sel_ent, sel_noise, illegal;
  logic              ent_read_ok, noise_read_ok, noise_wr_en;
  logic              noise_q, fresh, consume;
  logic [SEED_W-1:0] seed;
  ent_status_e       status;
  logic [WORD_W-1:0] word;
  logic [XLEN-1:0]   rdata_d;

  assign op = csr_op_e'(csr_op_i);

  entropy_access_chk #(.ENT_ADDR(ENT_ADDR), .NOISE_ADDR(NOISE_ADDR)) u_chk (
    .req_i          (csr_req_i),
    .addr_i         (csr_addr_i),
    .op_i           (op),
    .priv_i         (csr_priv_i),
    .src_zero_i     (csr_src_zero_i),
    .sel_ent_o      (sel_ent),
    .sel_noise_o    (sel_noise),
    .illegal_o      (illegal),
    .ent_read_ok_o  (ent_read_ok),
    .noise_read_ok_o(noise_read_ok),
    .noise_wr_en_o  (noise_wr_en)
  );

  noise_test_reg #(.IMPL(NOISE_IMPL)) u_noise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(noise_wr_en),
    .op_i   (op),
    .bit_i  (csr_wdata_i[31]),
    .noise_o(noise_q)
  );

  // A sample is consumed only by a legal read that reports ES16.
  assign consume = ent_read_ok && !noise_q && fresh;

  entropy_sample_buf u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_valid_i(smp_valid_i),
    .smp_data_i (smp_data_i),
    .consume_i  (consume),
    .fresh_o    (fresh),
    .seed_o     (seed)
  );

  always_comb begin
    if (noise_q)    status = ST_BIST;
    else if (fresh) status = ST_ES16;
    else            status = ST_WAIT;
    word = '0;
    if (ent_read_ok)        word = pack_entropy(status, seed);
    else if (noise_read_ok) word[31] = noise_q;
    rdata_d = '0;
    rdata_d[WORD_W-1:0] = word;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_hit_o     <= 1'b0;
      rsp_illegal_o <= 1'b0;
      rsp_rdata_o   <= '0;
    end else begin
      rsp_valid_o   <= csr_req_i;
      rsp_hit_o     <= sel_ent || sel_noise;
      rsp_illegal_o <= illegal;
      rsp_rdata_o   <= rdata_d;
    end
  end

  AST_LOW_PRIV_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ent || sel_noise) && csr_priv_i != PRIV_MACHINE
      |=> rsp_illegal_o && rsp_rdata_o == '0); // R1
  AST_ENT_WRITE_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ent && op == OP_WRITE |=> rsp_illegal_o); // R2
  AST_ENT_NO_CONSUME_ON_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal |-> !consume && !noise_wr_en); // R2
  AST_PURE_READ_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ent && csr_priv_i == PRIV_MACHINE && csr_src_zero_i && op != OP_WRITE
      |=> !rsp_illegal_o); // R3
  AST_SEED_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_rdata_o[31:30] != ST_ES16 |-> rsp_rdata_o[15:0] == '0); // R4
  AST_BIST_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_read_ok && noise_q |=> rsp_rdata_o[31:30] == ST_BIST); // R6
  AST_BIST_NO_CONSUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    noise_q |-> !consume); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_req_i |=> !rsp_valid_o && !rsp_hit_o && !rsp_illegal_o && rsp_rdata_o == '0); // R10
  AST_REQ_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_req_i |=> rsp_valid_o); // R10

  generate
    if (XLEN > WORD_W) begin : g_upper_chk
      AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_rdata_o[XLEN-1:WORD_W] == '0); // R8
    end
  endgenerate
endmodule

// File: tb/entropy_csr_top_tb.sv
module entropy_csr_top_tb;
  localparam int XLEN = 64;
  localparam logic [11:0] A_ENT = 12'h015;
  localparam logic [11:0] A_NOI = 12'h7A9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0] op = '0;
  logic [XLEN-1:0] wdata = '0;
  logic [1:0] priv = 2'b11;
  logic srcz = 1'b0;
  logic sval = 1'b0;
  logic [15:0] sdata = '0;

  logic v0, h0, i0, v1, h1, i1;
  logic [XLEN-1:0] d0, d1;

  int compared = 0;
  int mismatched = 0;
  string tag = "R10";
  bit done = 1'b0;

  // model state per instance (0: noise implemented, 1: absent)
  bit m_fresh [2];
  logic [15:0] m_seed [2];
  bit m_noise [2];
  bit e_v [2];
  bit e_h [2];
  bit e_i [2];
  logic [XLEN-1:0] e_d [2];

  always #2ns clk = ~clk;

  entropy_csr_top #(.XLEN(XLEN), .NOISE_IMPL(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_req_i(req), .csr_addr_i(addr),
    .csr_op_i(op), .csr_wdata_i(wdata), .csr_priv_i(priv),
    .csr_src_zero_i(srcz), .smp_valid_i(sval), .smp_data_i(sdata),
    .rsp_valid_o(v0), .rsp_hit_o(h0), .rsp_illegal_o(i0), .rsp_rdata_o(d0));

  entropy_csr_top #(.XLEN(XLEN), .NOISE_IMPL(1'b0)) u_dut_absent (
    .clk_i(clk), .rst_ni(rst_n), .csr_req_i(req), .csr_addr_i(addr),
    .csr_op_i(op), .csr_wdata_i(wdata), .csr_priv_i(priv),
    .csr_src_zero_i(srcz), .smp_valid_i(sval), .smp_data_i(sdata),
    .rsp_valid_o(v1), .rsp_hit_o(h1), .rsp_illegal_o(i1), .rsp_rdata_o(d1));

  // Behavioural reference, one step per rising edge.
  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      bit writes;
      e_v[k] = 0; e_h[k] = 0; e_i[k] = 0; e_d[k] = '0;
      if (!rst_n) begin
        m_fresh[k] = 0; m_seed[k] = '0; m_noise[k] = 0;
      end else begin
        writes = (op == 2'd1) || ((op >= 2'd2) && !srcz);
        e_v[k] = req;
        if (req && (addr == A_ENT || addr == A_NOI)) begin
          e_h[k] = 1;
          if (priv != 2'b11) e_i[k] = 1;
          else if (addr == A_ENT) begin
            if (writes) e_i[k] = 1;
            else if (m_noise[k]) e_d[k] = '0;
            else if (m_fresh[k]) begin
              e_d[k] = (64'd2 << 30) + m_seed[k];
              m_fresh[k] = 0;
            end else e_d[k] = 64'd1 << 30;
          end else begin
            e_d[k] = 64'(m_noise[k]) << 31;
            if (k == 0 && writes) begin
              if (op == 2'd1) m_noise[k] = wdata[31];
              else if (op == 2'd2) m_noise[k] = m_noise[k] | wdata[31];
              else m_noise[k] = m_noise[k] & ~wdata[31];
            end
          end
        end
        if (sval) begin m_fresh[k] = 1; m_seed[k] = sdata; end
      end
    end
  end

  task automatic compare();
    logic [XLEN-1:0] gd [2];
    logic gv [2], gh [2], gi [2];
    gv[0] = v0; gh[0] = h0; gi[0] = i0; gd[0] = d0;
    gv[1] = v1; gh[1] = h1; gi[1] = i1; gd[1] = d1;
    for (int k = 0; k < 2; k++) begin
      compared++;
      if (gv[k] !== e_v[k] || gh[k] !== e_h[k] || gi[k] !== e_i[k] || gd[k] !== e_d[k]) begin
        mismatched++;
        $display("FAIL %s inst%0d: got v%0b h%0b i%0b d=%h, exp v%0b h%0b i%0b d=%h",
                 tag, k, gv[k], gh[k], gi[k], gd[k], e_v[k], e_h[k], e_i[k], e_d[k]);
      end
    end
  endtask

  // one clock: drive at falling edge, check the previous step's response
  task automatic step(input bit r, input logic [11:0] a, input logic [1:0] o,
                      input logic [XLEN-1:0] w, input logic [1:0] p, input bit z,
                      input bit sv, input logic [15:0] sd);
    @(negedge clk);
    compare();
    req = r; addr = a; op = o; wdata = w; priv = p; srcz = z; sval = sv; sdata = sd;
  endtask

  task automatic idle(); step(0, '0, 0, '0, 2'b11, 0, 0, '0); endtask
  task automatic rd(input logic [11:0] a); step(1, a, 0, '0, 2'b11, 1, 0, '0); endtask
  task automatic smp(input logic [15:0] s); step(0, '0, 0, '0, 2'b11, 0, 1, s); endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state check (R10)
    tag = "R10"; compared++;
    if (v0 !== 0 || d0 !== '0 || i0 !== 0) begin
      mismatched++; $display("FAIL R10 reset: got v%0b d=%h, exp 0", v0, d0);
    end
    rst_n = 1'b1;
    idle(); idle();
    tag = "R5"; rd(A_ENT); idle();            // WAIT
    smp(16'hBEEF); rd(A_ENT); rd(A_ENT); idle(); // ES16 then WAIT
    tag = "R5"; smp(16'h1234);
    step(1, A_ENT, 0, '0, 2'b11, 1, 1, 16'h5678); // read gets 1234, 5678 held
    rd(A_ENT); rd(A_ENT); idle();
    tag = "R3"; smp(16'hA5A5);
    step(1, A_ENT, 2, 64'hFFFF_FFFF, 2'b11, 1, 0, '0); idle();
    smp(16'h0F0F); step(1, A_ENT, 3, '1, 2'b11, 1, 0, '0); idle();
    tag = "R2"; smp(16'hC3C3);
    step(1, A_ENT, 1, '0, 2'b11, 1, 0, '0);
    step(1, A_ENT, 2, 64'h1, 2'b11, 0, 0, '0);
    step(1, A_ENT, 3, 64'h1, 2'b11, 0, 0, '0);
    rd(A_ENT); idle();                          // still ES16 C3C3
    tag = "R1"; smp(16'h7E7E);
    step(1, A_ENT, 0, '0, 2'b00, 1, 0, '0);
    step(1, A_ENT, 0, '0, 2'b01, 1, 0, '0);
    step(1, A_NOI, 1, '1, 2'b01, 0, 0, '0);
    rd(A_NOI); rd(A_ENT); idle();
    tag = "R7"; step(1, A_NOI, 1, '1, 2'b11, 0, 0, '0); rd(A_NOI);
    step(1, A_NOI, 3, 64'h8000_0000, 2'b11, 1, 0, '0); rd(A_NOI);
    step(1, A_NOI, 3, 64'h8000_0000, 2'b11, 0, 0, '0); rd(A_NOI);
    step(1, A_NOI, 2, 64'h7FFF_FFFF, 2'b11, 0, 0, '0); rd(A_NOI);
    step(1, A_NOI, 2, 64'h8000_0000, 2'b11, 0, 0, '0); rd(A_NOI);
    tag = "R6"; smp(16'h9999); rd(A_ENT); rd(A_ENT);
    step(1, A_NOI, 1, '0, 2'b11, 0, 0, '0);
    tag = "R9"; rd(A_ENT); rd(A_NOI); idle();
    tag = "R10"; rd(12'h300); step(1, 12'h016, 1, '1, 2'b00, 0, 0, '0); idle();
    tag = "R4";
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      int s = $urandom_range(0, 5);
      a = (s < 3) ? A_ENT : (s < 5) ? A_NOI : 12'($urandom);
      step($urandom_range(0, 3) != 0, a, 2'($urandom),
           {$urandom, $urandom}, ($urandom_range(0, 4) == 0) ? 2'($urandom) : 2'b11,
           1'($urandom), $urandom_range(0, 2) == 0, 16'($urandom));
    end
    tag = "R8"; idle(); idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule